// File: doc/BRIEF.md
# Paravirtual Device Control Register File

This block is the host-visible register front end of a legacy paravirtual I/O device. A host issues single-cycle reads and writes through a small I/O port that carries an 8-bit byte offset, an access size and 32 bits of data. Through that port the host reads the fixed device feature word, writes its accepted feature word, and programs the page number of the single supported queue. It also selects a queue, kicks the queue engine by writing a queue number, and walks the device status handshake.

The block has a level interrupt output backed by an interrupt status register. The queue engine raises it through a set input. The host reads the status register once, which returns the value and clears it. Writing zero to device status is a soft reset of the block's queue and handshake state. A 128-byte device configuration window is read from a byte vector supplied by the device model. Only its first `CFG_LEN` bytes are populated, and host writes to the window are discarded.

Read data is combinational in the cycle `io_rd` is high. Every register write, the read-clear side effect and every output register update at the rising clock edge that ends the access cycle.

Top module: `pvdev_regs`

## Requirements
- R1: A 32-bit read (size code 2) at offset 0x00 returns `DEV_FEATURES` (default 0x00000001).
- R2: A 16-bit read (size code 1) at offset 0x0C returns `QUEUE_SIZE` (default 32) in bits 15:0, with zeros above.
- R3: A 32-bit write at 0x08 stores the queue page number and drives it on `queue_pfn_o` after the edge. A 32-bit read at 0x08 returns that value while the selected queue is 0, and returns 0 for any other selected queue.
- R4: A 16-bit write at 0x0E stores the selected queue number from `io_wdata[15:0]`.
- R5: A byte write (size code 0) of a nonzero value at 0x12 stores it unchanged as device status. The status is readable by a byte read at 0x12 and drives `status_o`.
- R6: A byte write of 0 at 0x12 clears queue select, device status, interrupt status, `irq_o` and the queue page number after the edge. The guest feature word is left unchanged.
- R7: A high `set_irq` sets bit 0 of the interrupt status, and `irq_o` is high after that edge.
- R8: A byte read at 0x13 returns the current interrupt status. After the edge the status is 0 and `irq_o` is low.
- R9: When `set_irq` and an interrupt status read occur in the same cycle, bit 0 stays set and `irq_o` stays high after the edge.
- R10: A 16-bit write at 0x10 makes `notify_valid` high for exactly the following cycle, with `notify_queue` equal to the written `io_wdata[15:0]`.
- R11: A byte read at offset 0x14+i (i from 0 to 127) returns `cfg_bytes[8*i+:8]` when i < `CFG_LEN` and returns 0 otherwise. Byte writes in that range change nothing.
- R12: A 32-bit write at 0x04 drives the written value on `guest_feat_o` after the edge.
- R13: An access whose size code does not match the register's listed size has no effect, and as a read it returns 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| io_wr | input | 1 | Write strobe for one cycle |
| io_rd | input | 1 | Read strobe for one cycle |
| io_addr | input | 8 | Byte offset in the register window |
| io_size | input | 2 | Access size: 0 byte, 1 half-word, 2 word |
| io_wdata | input | 32 | Write data, least significant bytes used |
| io_rdata | output | 32 | Read data, valid in the strobe cycle |
| set_irq | input | 1 | Queue engine request to raise the interrupt |
| cfg_bytes | input | 8*CFG_LEN | Device configuration bytes, byte i in bits 8i+7:8i |
| irq_o | output | 1 | Level interrupt |
| notify_valid | output | 1 | Queue notify pulse |
| notify_queue | output | 16 | Queue number carried by the notify pulse |
| queue_pfn_o | output | 32 | Stored queue page number |
| status_o | output | 8 | Device status |
| guest_feat_o | output | 32 | Guest accepted feature word |

## Verification
The bound checker watches the handshake on every cycle. It checks that the interrupt line matches a nonzero interrupt status, that a set request beats a same-cycle read-clear, that a read-clear without a set drops the line, that a zero status write wipes the state, that a nonzero status write is stored as written, and that every notify pulse traces back to a notify write. The register map itself only shows up in the bench's scenarios. Those scenarios cover the constant feature and size values, the queue-select gating of the page number readback, the configuration window boundary at `CFG_LEN`, and the discarding of mismatched sizes and window writes.

// File: rtl/pvdev_pkg.sv
package pvdev_pkg;

    typedef enum logic [1:0] {
        SZ_BYTE = 2'd0,
        SZ_HALF = 2'd1,
        SZ_WORD = 2'd2
    } io_size_e;

    localparam logic [7:0] OFS_DEVFEAT = 8'h00;
    localparam logic [7:0] OFS_GSTFEAT = 8'h04;
    localparam logic [7:0] OFS_QPFN    = 8'h08;
    localparam logic [7:0] OFS_QSIZE   = 8'h0C;
    localparam logic [7:0] OFS_QSEL    = 8'h0E;
    localparam logic [7:0] OFS_NOTIFY  = 8'h10;
    localparam logic [7:0] OFS_STATUS  = 8'h12;
    localparam logic [7:0] OFS_ISR     = 8'h13;
    localparam logic [7:0] OFS_CFG     = 8'h14;

    localparam int CFG_WIN_BYTES = 128;
    localparam int CFG_IDX_W     = $clog2(CFG_WIN_BYTES);

    // One-hot style strobes produced by the decoder for a single access.
    typedef struct packed {
        logic                 rd_devfeat;
        logic                 rd_qpfn;
        logic                 rd_qsize;
        logic                 rd_status;
        logic                 rd_isr;
        logic                 rd_cfg;
        logic                 wr_gstfeat;
        logic                 wr_qpfn;
        logic                 wr_qsel;
        logic                 wr_notify;
        logic                 wr_status;
        logic [CFG_IDX_W-1:0] cfg_idx;
    } io_dec_t;

    function automatic logic reg_hit(input logic [7:0] addr, input logic [1:0] size,
                                     input logic [7:0] ofs, input io_size_e want);
        return (addr == ofs) && (io_size_e'(size) == want);
    endfunction

    function automatic logic cfg_hit(input logic [7:0] addr, input logic [1:0] size);
        return (addr >= OFS_CFG) && ({1'b0, addr} < ({1'b0, OFS_CFG} + 9'(CFG_WIN_BYTES)))
               && (io_size_e'(size) == SZ_BYTE);
    endfunction

endpackage

// File: rtl/pvdev_decode.sv
module pvdev_decode
    import pvdev_pkg::*;
(
    input  logic       io_wr,
    input  logic       io_rd,
    input  logic [7:0] io_addr,
    input  logic [1:0] io_size,
    output io_dec_t    dec
);
    logic [7:0] cfg_off;

    assign cfg_off = io_addr - OFS_CFG;

    always_comb begin
        dec            = '0;
        dec.rd_devfeat = io_rd && reg_hit(io_addr, io_size, OFS_DEVFEAT, SZ_WORD);
        dec.rd_qpfn    = io_rd && reg_hit(io_addr, io_size, OFS_QPFN,    SZ_WORD);
        dec.rd_qsize   = io_rd && reg_hit(io_addr, io_size, OFS_QSIZE,   SZ_HALF);
        dec.rd_status  = io_rd && reg_hit(io_addr, io_size, OFS_STATUS,  SZ_BYTE);
        dec.rd_isr     = io_rd && reg_hit(io_addr, io_size, OFS_ISR,     SZ_BYTE);
        dec.rd_cfg     = io_rd && cfg_hit(io_addr, io_size);
        dec.wr_gstfeat = io_wr && reg_hit(io_addr, io_size, OFS_GSTFEAT, SZ_WORD);
        dec.wr_qpfn    = io_wr && reg_hit(io_addr, io_size, OFS_QPFN,    SZ_WORD);
        dec.wr_qsel    = io_wr && reg_hit(io_addr, io_size, OFS_QSEL,    SZ_HALF);
        dec.wr_notify  = io_wr && reg_hit(io_addr, io_size, OFS_NOTIFY,  SZ_HALF);
        dec.wr_status  = io_wr && reg_hit(io_addr, io_size, OFS_STATUS,  SZ_BYTE);
        dec.cfg_idx    = cfg_off[CFG_IDX_W-1:0];
    end
endmodule

// File: rtl/pvdev_ctrl.sv
module pvdev_ctrl
    import pvdev_pkg::*;
#(
    parameter int PFN_W  = 32,
    parameter int QSEL_W = 16,
    parameter int STAT_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  io_dec_t           dec,
    input  logic [31:0]       wdata,
    input  logic              set_irq,
    output logic [31:0]       guest_feat,
    output logic [PFN_W-1:0]  qpfn,
    output logic [QSEL_W-1:0] qsel,
    output logic [STAT_W-1:0] status,
    output logic [STAT_W-1:0] isr,
    output logic              irq,
    output logic              notify_valid,
    output logic [QSEL_W-1:0] notify_queue
);
    logic soft_rst;

    assign soft_rst = dec.wr_status && (wdata[STAT_W-1:0] == '0);

    always_ff @(posedge clk) begin
        if (rst || soft_rst) begin
            qpfn   <= '0;
            qsel   <= '0;
            status <= '0;
            isr    <= '0;
            irq    <= 1'b0;
        end else begin
            if (dec.wr_qpfn)   qpfn   <= wdata[PFN_W-1:0];
            if (dec.wr_qsel)   qsel   <= wdata[QSEL_W-1:0];
            if (dec.wr_status) status <= wdata[STAT_W-1:0];
            if (set_irq) begin
                isr <= isr | STAT_W'(1);
                irq <= 1'b1;
            end else if (dec.rd_isr) begin
                isr <= '0;
                irq <= 1'b0;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            guest_feat <= '0;
        end else if (dec.wr_gstfeat) begin
            guest_feat <= wdata;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            notify_valid <= 1'b0;
            notify_queue <= '0;
        end else begin
            notify_valid <= dec.wr_notify;
            if (dec.wr_notify) notify_queue <= wdata[QSEL_W-1:0];
        end
    end
endmodule

// File: rtl/pvdev_cfg_window.sv
module pvdev_cfg_window
    import pvdev_pkg::*;
#(
    parameter int CFG_LEN = 8
) (
    input  logic [CFG_LEN*8-1:0]  cfg_bytes,
    input  logic [CFG_IDX_W-1:0]  idx,
    output logic [7:0]            rbyte
);
    logic [7:0] win [CFG_WIN_BYTES];

    for (genvar i = 0; i < CFG_WIN_BYTES; i++) begin : g_win
        if (i < CFG_LEN) begin : g_pop
            assign win[i] = cfg_bytes[i*8 +: 8];
        end else begin : g_empty
            assign win[i] = 8'h00;
        end
    end

    assign rbyte = win[idx];
endmodule

// File: rtl/pvdev_regs.sv
module pvdev_regs
    import pvdev_pkg::*;
#(
    parameter logic [31:0] DEV_FEATURES = 32'h0000_0001,
    parameter int          QUEUE_SIZE   = 32,
    parameter int          CFG_LEN      = 8
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 io_wr,
    input  logic                 io_rd,
    input  logic [7:0]           io_addr,
    input  logic [1:0]           io_size,
    input  logic [31:0]          io_wdata,
    output logic [31:0]          io_rdata,
    input  logic                 set_irq,
    input  logic [CFG_LEN*8-1:0] cfg_bytes,
    output logic                 irq_o,
    output logic                 notify_valid,
    output logic [15:0]          notify_queue,
    output logic [31:0]          queue_pfn_o,
    output logic [7:0]           status_o,
    output logic [31:0]          guest_feat_o
);
    localparam int QSEL_W = 16;
    localparam int STAT_W = 8;
    localparam logic [15:0] QSIZE_VAL = 16'(QUEUE_SIZE);

    io_dec_t           dec;
    logic [QSEL_W-1:0] qsel_val;
    logic [STAT_W-1:0] isr_val;
    logic [7:0]        cfg_rbyte;

    pvdev_decode u_dec (
        .io_wr   (io_wr),
        .io_rd   (io_rd),
        .io_addr (io_addr),
        .io_size (io_size),
        .dec     (dec)
    );

    pvdev_ctrl #(.PFN_W(32), .QSEL_W(QSEL_W), .STAT_W(STAT_W)) u_ctrl (
        .clk          (clk),
        .rst          (rst),
        .dec          (dec),
        .wdata        (io_wdata),
        .set_irq      (set_irq),
        .guest_feat   (guest_feat_o),
        .qpfn         (queue_pfn_o),
        .qsel         (qsel_val),
        .status       (status_o),
        .isr          (isr_val),
        .irq          (irq_o),
        .notify_valid (notify_valid),
        .notify_queue (notify_queue)
    );

    pvdev_cfg_window #(.CFG_LEN(CFG_LEN)) u_cfg (
        .cfg_bytes (cfg_bytes),
        .idx       (dec.cfg_idx),
        .rbyte     (cfg_rbyte)
    );

    always_comb begin
        io_rdata = '0;
        if (dec.rd_devfeat) io_rdata = DEV_FEATURES;
        if (dec.rd_qsize)   io_rdata = {16'h0, QSIZE_VAL};
        if (dec.rd_qpfn)    io_rdata = (qsel_val == '0) ? queue_pfn_o : '0;
        if (dec.rd_status)  io_rdata = {24'h0, status_o};
        if (dec.rd_isr)     io_rdata = {24'h0, isr_val};
        if (dec.rd_cfg)     io_rdata = {24'h0, cfg_rbyte};
    end
endmodule

// File: rtl/pvdev_regs_chk.sv
module pvdev_regs_chk (
    input logic        clk,
    input logic        rst,
    input logic        io_wr,
    input logic        io_rd,
    input logic [7:0]  io_addr,
    input logic [1:0]  io_size,
    input logic [31:0] io_wdata,
    input logic        set_irq,
    input logic        irq_o,
    input logic        notify_valid,
    input logic [31:0] queue_pfn_o,
    input logic [7:0]  status_o,
    input logic [7:0]  isr_val
);
    logic st_wr, isr_rd, ntf_wr;

    assign st_wr  = io_wr && io_addr == 8'h12 && io_size == 2'd0;
    assign isr_rd = io_rd && io_addr == 8'h13 && io_size == 2'd0;
    assign ntf_wr = io_wr && io_addr == 8'h10 && io_size == 2'd1;

    AST_IRQ_TRACKS_ISR: assert property (@(posedge clk) disable iff (rst)
        irq_o == (isr_val != 8'h00)); // R7

    AST_SET_BEATS_CLEAR: assert property (@(posedge clk) disable iff (rst)
        (!rst && set_irq && !(st_wr && io_wdata[7:0] == 8'h00)) |=> irq_o); // R9

    AST_READ_CLEARS: assert property (@(posedge clk) disable iff (rst)
        (!rst && isr_rd && !set_irq) |=> !irq_o); // R8

    AST_SOFT_RESET: assert property (@(posedge clk) disable iff (rst)
        (!rst && st_wr && io_wdata[7:0] == 8'h00) |=> (status_o == 8'h00 && queue_pfn_o == 32'h0 && !irq_o)); // R6

    AST_STATUS_STORED: assert property (@(posedge clk) disable iff (rst)
        (!rst && st_wr && io_wdata[7:0] != 8'h00) |=> status_o == $past(io_wdata[7:0])); // R5

    AST_NOTIFY_SOURCE: assert property (@(posedge clk) disable iff (rst)
        notify_valid |-> $past(ntf_wr && !rst)); // R10
endmodule

bind pvdev_regs pvdev_regs_chk u_chk (
    .clk          (clk),
    .rst          (rst),
    .io_wr        (io_wr),
    .io_rd        (io_rd),
    .io_addr      (io_addr),
    .io_size      (io_size),
    .io_wdata     (io_wdata),
    .set_irq      (set_irq),
    .irq_o        (irq_o),
    .notify_valid (notify_valid),
    .queue_pfn_o  (queue_pfn_o),
    .status_o     (status_o),
    .isr_val      (isr_val)
);

// File: tb/pvdev_regs_test.sv
module pvdev_regs_test;
    localparam int CFG_LEN = 8;
    localparam int NV = 20;

    logic                 clk = 1'b0;
    logic                 rst = 1'b1;
    logic                 io_wr = 1'b0, io_rd = 1'b0;
    logic [7:0]           io_addr = '0;
    logic [1:0]           io_size = '0;
    logic [31:0]          io_wdata = '0;
    logic [31:0]          io_rdata;
    logic                 set_irq = 1'b0;
    logic [CFG_LEN*8-1:0] cfg_bytes;
    logic                 irq_o, notify_valid;
    logic [15:0]          notify_queue;
    logic [31:0]          queue_pfn_o, guest_feat_o;
    logic [7:0]           status_o;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;
    logic [31:0] rd_val;

    always #4 clk = ~clk;

    for (genvar i = 0; i < CFG_LEN; i++) begin : g_cfg
        assign cfg_bytes[i*8 +: 8] = 8'h10 + 8'(i);
    end

    pvdev_regs #(.CFG_LEN(CFG_LEN)) uut (
        .clk(clk), .rst(rst), .io_wr(io_wr), .io_rd(io_rd), .io_addr(io_addr),
        .io_size(io_size), .io_wdata(io_wdata), .io_rdata(io_rdata),
        .set_irq(set_irq), .cfg_bytes(cfg_bytes), .irq_o(irq_o),
        .notify_valid(notify_valid), .notify_queue(notify_queue),
        .queue_pfn_o(queue_pfn_o), .status_o(status_o), .guest_feat_o(guest_feat_o)
    );

    // Vector: {req[3:0], wr, rd, addr[7:0], size[1:0], wdata[31:0], exp[31:0]}
    localparam logic [79:0] VECS [NV] = '{
        {4'd1,  1'b0, 1'b1, 8'h00, 2'd2, 32'h0,        32'h1},        // R1
        {4'd2,  1'b0, 1'b1, 8'h0C, 2'd1, 32'h0,        32'd32},       // R2
        {4'd3,  1'b1, 1'b0, 8'h08, 2'd2, 32'h000ABCDE, 32'h0},
        {4'd3,  1'b0, 1'b1, 8'h08, 2'd2, 32'h0,        32'h000ABCDE}, // R3
        {4'd4,  1'b1, 1'b0, 8'h0E, 2'd1, 32'h3,        32'h0},
        {4'd4,  1'b0, 1'b1, 8'h08, 2'd2, 32'h0,        32'h0},        // R4 R3 other queue
        {4'd4,  1'b1, 1'b0, 8'h0E, 2'd1, 32'h0,        32'h0},
        {4'd4,  1'b0, 1'b1, 8'h08, 2'd2, 32'h0,        32'h000ABCDE}, // R4 back to queue 0
        {4'd5,  1'b1, 1'b0, 8'h12, 2'd0, 32'h83,       32'h0},
        {4'd5,  1'b0, 1'b1, 8'h12, 2'd0, 32'h0,        32'h83},       // R5
        {4'd11, 1'b0, 1'b1, 8'h14, 2'd0, 32'h0,        32'h10},       // R11 first byte
        {4'd11, 1'b0, 1'b1, 8'h1B, 2'd0, 32'h0,        32'h17},       // R11 last populated
        {4'd11, 1'b0, 1'b1, 8'h1C, 2'd0, 32'h0,        32'h0},        // R11 past CFG_LEN
        {4'd11, 1'b0, 1'b1, 8'h93, 2'd0, 32'h0,        32'h0},        // R11 window end
        {4'd11, 1'b1, 1'b0, 8'h15, 2'd0, 32'hFF,       32'h0},
        {4'd11, 1'b0, 1'b1, 8'h15, 2'd0, 32'h0,        32'h11},       // R11 write ignored
        {4'd13, 1'b0, 1'b1, 8'h00, 2'd0, 32'h0,        32'h0},        // R13 wrong size read
        {4'd13, 1'b1, 1'b0, 8'h08, 2'd0, 32'h55,       32'h0},
        {4'd13, 1'b0, 1'b1, 8'h08, 2'd2, 32'h0,        32'h000ABCDE}, // R13 wrong size write
        {4'd13, 1'b0, 1'b1, 8'h12, 2'd1, 32'h0,        32'h0}         // R13 status as half
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // Drives one access at a falling edge, samples read data mid-cycle,
    // and returns at the next falling edge with the inputs idle.
    task automatic access(input logic wr, input logic rd, input logic [7:0] addr,
                          input logic [1:0] size, input logic [31:0] wdata,
                          input logic irq_req, output logic [31:0] rdata);
        io_wr = wr; io_rd = rd; io_addr = addr; io_size = size;
        io_wdata = wdata; set_irq = irq_req;
        #2 rdata = io_rdata;
        @(negedge clk);
        io_wr = 1'b0; io_rd = 1'b0; set_irq = 1'b0; io_wdata = '0;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual hung expected done");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // Reset state
        check("R7 reset irq", 32'(irq_o), 32'h0);
        check("R10 reset notify", 32'(notify_valid), 32'h0);
        check("R6 reset status", 32'(status_o), 32'h0);
        check("R3 reset pfn", queue_pfn_o, 32'h0);

        for (int v = 0; v < NV; v++) begin
            logic [79:0] e;
            e = VECS[v];
            access(e[75], e[74], e[73:66], e[65:64], e[63:32], 1'b0, rd_val);
            if (e[74]) check($sformatf("R%0d vector %0d", e[79:76], v), rd_val, e[31:0]);
        end

        // R12 guest features
        access(1'b1, 1'b0, 8'h04, 2'd2, 32'hCAFE0001, 1'b0, rd_val);
        check("R12 guest features", guest_feat_o, 32'hCAFE0001);

        // R7 set interrupt
        check("R7 irq low before set", 32'(irq_o), 32'h0);
        access(1'b0, 1'b0, 8'h00, 2'd0, 32'h0, 1'b1, rd_val);
        check("R7 irq after set", 32'(irq_o), 32'h1);

        // R8 read returns value then clears
        access(1'b0, 1'b1, 8'h13, 2'd0, 32'h0, 1'b0, rd_val);
        check("R8 isr read value", rd_val, 32'h1);
        check("R8 irq cleared", 32'(irq_o), 32'h0);
        access(1'b0, 1'b1, 8'h13, 2'd0, 32'h0, 1'b0, rd_val);
        check("R8 isr zero after read", rd_val, 32'h0);

        // R9 set and read-clear in the same cycle
        access(1'b0, 1'b1, 8'h13, 2'd0, 32'h0, 1'b1, rd_val);
        check("R9 irq kept", 32'(irq_o), 32'h1);
        access(1'b0, 1'b1, 8'h13, 2'd0, 32'h0, 1'b0, rd_val);
        check("R9 isr still set", rd_val, 32'h1);

        // R10 notify pulse
        access(1'b1, 1'b0, 8'h10, 2'd1, 32'h0000_0005, 1'b0, rd_val);
        check("R10 notify valid", 32'(notify_valid), 32'h1);
        check("R10 notify queue", 32'(notify_queue), 32'h5);
        @(negedge clk);
        check("R10 notify one cycle", 32'(notify_valid), 32'h0);

        // R6 soft reset through status write of zero
        access(1'b1, 1'b0, 8'h0E, 2'd1, 32'h2, 1'b0, rd_val);
        access(1'b0, 1'b0, 8'h00, 2'd0, 32'h0, 1'b1, rd_val);
        access(1'b1, 1'b0, 8'h12, 2'd0, 32'h0, 1'b0, rd_val);
        check("R6 status cleared", 32'(status_o), 32'h0);
        check("R6 pfn cleared", queue_pfn_o, 32'h0);
        check("R6 irq cleared", 32'(irq_o), 32'h0);
        check("R6 guest features kept", guest_feat_o, 32'hCAFE0001);
        access(1'b1, 1'b0, 8'h08, 2'd2, 32'h77, 1'b0, rd_val);
        access(1'b0, 1'b1, 8'h08, 2'd2, 32'h0, 1'b0, rd_val);
        check("R6 queue select cleared", rd_val, 32'h77);
        access(1'b0, 1'b1, 8'h0C, 2'd1, 32'h0, 1'b0, rd_val);
        check("R6 queue size after soft reset", rd_val, 32'd32);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule